// File: doc/BRIEF.md
# PLL Power-Up Programming Sequencer

This block loads a serially programmed integer-N frequency synthesizer after power is applied. It keeps three 24-bit configuration words: a reference-divider word, a control word and a feedback-divider word. On request it sends them over a three-wire link made of a serial clock, a data line and a latch strobe. Each word goes out most significant bit first. After the last bit of each word, the latch strobe pulses so the synthesizer takes the word. The fixed order is reference, then control, then feedback.

The synthesizer's oscillator bias needs time to settle after the control word powers it up. For that reason, a programmable idle interval is always placed between the control latch and the feedback latch. No such pause is placed between the first two words. One input bit picks either a long or a short interval, and both lengths are parameters counted in system-clock cycles. The destination bits of every word and the test-mode bit of the reference word are forced by the sequencer. A value stored by the host therefore cannot misroute a word or enable a test mode.

While the synthesizer is powered down, the host may store a new feedback value. The sequencer marks this as pending. When power returns, it runs the whole three-word sequence by itself, wait included. If the feedback field was not changed, power-up causes no traffic.

Top module: `pll_prog_seq`

## Requirements
- R1: After `start` is accepted in idle, exactly three words leave on the link in the order reference, control, feedback. Each word is 24 bits, most significant first, and each bit is taken on a rising edge of `spi_sclk`. `spi_data` never changes while `spi_sclk` stays high, and `spi_le` is high only while `busy` is high.
- R2: The two lowest bits of each word sent are forced to the destination code. The codes are 01 for the reference word, 00 for the control word and 10 for the feedback word. The stored value of those bits is ignored.
- R3: In the reference word, bit 21 (test mode) is always sent as 0. All other bits from 23 down to 2 are sent as stored.
- R4: After the 24th bit, `spi_sclk` is low and `spi_le` rises. `spi_le` stays high for exactly 2*HALF_DIV system cycles, which is one serial-clock period, and no `spi_sclk` edge occurs while it is high.
- R5: The gap from the fall of the control word's `spi_le` to the rise of the feedback word's `spi_le` exceeds the gap between the reference and control words by at least the selected interval. The interval is WAIT_LONG cycles when `long_wait` is 1 and WAIT_SHORT cycles when it is 0, so the two choices differ by exactly WAIT_LONG-WAIT_SHORT.
- R6: `busy` rises on the cycle after a request is accepted. `done` is a single-cycle pulse after the feedback word's latch pulse ends, and `busy` is low during that pulse and afterwards.
- R7: While `busy` is high, `start` pulses are dropped and not queued. Register writes (`wr_en`) are also dropped, so the stored words are unchanged.
- R8: A feedback write (`wr_sel`=2) while `pwr_down` is high sets a pending flag if bits 23..2 differ from the stored feedback word. No sequence runs while `pwr_down` stays high. Once it falls, the full sequence runs without `start`, sending the new feedback value.
- R9: If `pwr_down` falls with nothing pending, no sequence runs. Nothing is pending when no feedback write was made, or when the written value matched in bits 23..2, or when the flag was already consumed by an earlier run.
- R10: While `rst` is high, and on the cycle after it, `spi_sclk`, `spi_data`, `spi_le`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a full programming run |
| long_wait | input | 1 | 1 selects the long settling interval, 0 the short one |
| pwr_down | input | 1 | Synthesizer power-down state, high while powered down |
| wr_en | input | 1 | Store `wr_data` into the word picked by `wr_sel` |
| wr_sel | input | 2 | Word select: 0 reference, 1 control, 2 feedback |
| wr_data | input | 24 | Word value to store |
| spi_sclk | output | 1 | Serial clock to the synthesizer |
| spi_data | output | 1 | Serial data, most significant bit first |
| spi_le | output | 1 | Latch strobe, high for one serial period after each word |
| busy | output | 1 | A programming run is in progress |
| done | output | 1 | One-cycle pulse when the feedback word has been latched |

## Verification
The settling-interval property reads `long_wait` at the moment the feedback strobe rises. It therefore relies on that input staying constant for the whole run. The bench changes it only while `busy` is low. The checker also counts latch strobes between the start of a run and `done`, so it assumes every run is started from reset-clean state. The stimulus never asserts `rst` in the middle of a sequence. Register writes and power-state changes are driven at falling clock edges and held for whole cycles, so each write is seen exactly once.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int PLL_WORD_W = 24;
  localparam int TEST_BIT   = 21;
  localparam int NUM_WORDS  = 3;

  localparam logic [1:0] CODE_REF  = 2'b01;
  localparam logic [1:0] CODE_CTRL = 2'b00;
  localparam logic [1:0] CODE_FB   = 2'b10;

  localparam logic [1:0] SEL_REF  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_FB   = 2'd2;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SEND_REF,
    SQ_SEND_CTRL,
    SQ_SETTLE,
    SQ_SEND_FB
  } seq_state_t;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LOW,
    SH_HIGH,
    SH_LATCH
  } shift_state_t;

  // Replace destination bits and optionally clear the test-mode bit.
  function automatic logic [PLL_WORD_W-1:0] fmt_word(
    input logic [PLL_WORD_W-1:0] w,
    input logic [1:0]            code,
    input logic                  clr_test
  );
    logic [PLL_WORD_W-1:0] r;
    r = {w[PLL_WORD_W-1:2], code};
    if (clr_test) r[TEST_BIT] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
  import pll_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [PLL_WORD_W-1:0] wr_data,
  input  logic                  lock,
  input  logic                  pwr_down,
  input  logic                  accept,
  output logic [PLL_WORD_W-1:0] ref_word,
  output logic [PLL_WORD_W-1:0] ctrl_word,
  output logic [PLL_WORD_W-1:0] fb_word,
  output logic                  auto_req
);

  logic [PLL_WORD_W-1:0] words_q [NUM_WORDS];
  logic                  pend_q;
  logic                  wr_ok;
  logic                  fb_changed;

  assign wr_ok      = wr_en && !lock;
  assign fb_changed = wr_ok && pwr_down && (wr_sel == SEL_FB) &&
                      (wr_data[PLL_WORD_W-1:2] != words_q[SEL_FB][PLL_WORD_W-1:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) words_q[i] <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (wr_sel == 2'(i)) words_q[i] <= wr_data;
      end
    end
  end

  // Pending rerun after a feedback change made during power-down.
  always_ff @(posedge clk) begin
    if (rst)             pend_q <= 1'b0;
    else if (fb_changed) pend_q <= 1'b1;
    else if (accept)     pend_q <= 1'b0;
  end

  assign auto_req  = pend_q && !pwr_down;
  assign ref_word  = words_q[SEL_REF];
  assign ctrl_word = words_q[SEL_CTRL];
  assign fb_word   = words_q[SEL_FB];

endmodule

// File: rtl/pll_seq_shift.sv
module pll_seq_shift
  import pll_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [PLL_WORD_W-1:0] word_in,
  output logic                  sclk_o,
  output logic                  sdata_o,
  output logic                  le_o,
  output logic                  fin_o
);

  localparam int LE_LEN = 2 * HALF_DIV;
  localparam int CNT_W  = $clog2(LE_LEN + 1);
  localparam int BIT_W  = $clog2(PLL_WORD_W + 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] LE_LAST   = CNT_W'(LE_LEN - 1);

  shift_state_t          st_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [BIT_W-1:0]      bits_q;
  logic [PLL_WORD_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SH_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      sreg_q  <= '0;
      sclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      le_o    <= 1'b0;
      fin_o   <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      unique case (st_q)
        SH_IDLE: begin
          if (go) begin
            sreg_q  <= word_in;
            sdata_o <= word_in[PLL_WORD_W-1];
            bits_q  <= BIT_W'(PLL_WORD_W - 1);
            cnt_q   <= '0;
            st_q    <= SH_LOW;
          end
        end
        SH_LOW: begin
          if (cnt_q == HALF_LAST) begin
            cnt_q  <= '0;
            sclk_o <= 1'b1;
            st_q   <= SH_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SH_HIGH: begin
          if (cnt_q == HALF_LAST) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
            if (bits_q == '0) begin
              le_o    <= 1'b1;
              sdata_o <= 1'b0;
              st_q    <= SH_LATCH;
            end else begin
              bits_q  <= bits_q - 1'b1;
              sreg_q  <= sreg_q << 1;
              sdata_o <= sreg_q[PLL_WORD_W-2];
              st_q    <= SH_LOW;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SH_LATCH: begin
          if (cnt_q == LE_LAST) begin
            cnt_q <= '0;
            le_o  <= 1'b0;
            fin_o <= 1'b1;
            st_q  <= SH_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_seq_wait.sv
module pll_seq_wait #(
  parameter int WAIT_LONG  = 250000,
  parameter int WAIT_SHORT = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic long_sel,
  output logic expire
);

  localparam int MAXW  = (WAIT_LONG > WAIT_SHORT) ? WAIT_LONG : WAIT_SHORT;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] LEN_L = CNT_W'(WAIT_LONG);
  localparam logic [CNT_W-1:0] LEN_S = CNT_W'(WAIT_SHORT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= (cnt_q == CNT_W'(1)) && !load;
      if (load)              cnt_q <= long_sel ? LEN_L : LEN_S;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int WAIT_LONG  = 250000,
  parameter int WAIT_SHORT = 30000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  long_wait,
  input  logic                  pwr_down,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [PLL_WORD_W-1:0] wr_data,
  output logic                  spi_sclk,
  output logic                  spi_data,
  output logic                  spi_le,
  output logic                  busy,
  output logic                  done
);

  seq_state_t            st_q;
  logic                  go_q;
  logic [PLL_WORD_W-1:0] word_q;
  logic                  wait_load_q;
  logic                  accept;
  logic                  auto_req;
  logic                  fin;
  logic                  expire;
  logic [PLL_WORD_W-1:0] ref_word, ctrl_word, fb_word;

  assign accept = (st_q == SQ_IDLE) && (start || auto_req);

  pll_seq_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .lock     (busy),
    .pwr_down (pwr_down),
    .accept   (accept),
    .ref_word (ref_word),
    .ctrl_word(ctrl_word),
    .fb_word  (fb_word),
    .auto_req (auto_req)
  );

  pll_seq_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .go     (go_q),
    .word_in(word_q),
    .sclk_o (spi_sclk),
    .sdata_o(spi_data),
    .le_o   (spi_le),
    .fin_o  (fin)
  );

  pll_seq_wait #(.WAIT_LONG(WAIT_LONG), .WAIT_SHORT(WAIT_SHORT)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .load    (wait_load_q),
    .long_sel(long_wait),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SQ_IDLE;
      go_q        <= 1'b0;
      word_q      <= '0;
      wait_load_q <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      go_q        <= 1'b0;
      wait_load_q <= 1'b0;
      done        <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (accept) begin
            go_q   <= 1'b1;
            word_q <= fmt_word(ref_word, CODE_REF, 1'b1);
            busy   <= 1'b1;
            st_q   <= SQ_SEND_REF;
          end
        end
        SQ_SEND_REF: begin
          if (fin) begin
            go_q   <= 1'b1;
            word_q <= fmt_word(ctrl_word, CODE_CTRL, 1'b0);
            st_q   <= SQ_SEND_CTRL;
          end
        end
        SQ_SEND_CTRL: begin
          if (fin) begin
            wait_load_q <= 1'b1;
            st_q        <= SQ_SETTLE;
          end
        end
        SQ_SETTLE: begin
          if (expire) begin
            go_q   <= 1'b1;
            word_q <= fmt_word(fb_word, CODE_FB, 1'b0);
            st_q   <= SQ_SEND_FB;
          end
        end
        SQ_SEND_FB: begin
          if (fin) begin
            busy <= 1'b0;
            done <= 1'b1;
            st_q <= SQ_IDLE;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk #(
  parameter int WAIT_LONG  = 250000,
  parameter int WAIT_SHORT = 30000
) (
  input logic clk,
  input logic rst,
  input logic long_wait,
  input logic spi_sclk,
  input logic spi_data,
  input logic spi_le,
  input logic busy,
  input logic done
);

  localparam logic [31:0] NEED_L = 32'(WAIT_LONG);
  localparam logic [31:0] NEED_S = 32'(WAIT_SHORT);

  logic        le_q;
  logic [1:0]  falls_q;
  logic [31:0] gap_q;
  logic        le_fell;

  assign le_fell = le_q && !spi_le;

  always_ff @(posedge clk) begin
    if (rst) begin
      le_q    <= 1'b0;
      falls_q <= '0;
      gap_q   <= '0;
    end else begin
      le_q <= spi_le;
      if (done)         falls_q <= '0;
      else if (le_fell) falls_q <= falls_q + 1'b1;
      if (le_fell && falls_q == 2'd1) gap_q <= '0;
      else if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 1'b1;
    end
  end

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!spi_sclk && !spi_le && !busy && !done));

  assert_le_clock_low_R4: assert property (@(posedge clk) disable iff (rst)
    spi_le |-> !spi_sclk);

  assert_data_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_data));

  assert_le_in_run_R1: assert property (@(posedge clk) disable iff (rst)
    spi_le |-> busy);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_after_run_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(spi_le) && falls_q == 2'd2) |-> (gap_q >= (long_wait ? NEED_L : NEED_S)));

endmodule

bind pll_prog_seq pll_prog_seq_chk #(
  .WAIT_LONG (WAIT_LONG),
  .WAIT_SHORT(WAIT_SHORT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .long_wait(long_wait),
  .spi_sclk (spi_sclk),
  .spi_data (spi_data),
  .spi_le   (spi_le),
  .busy     (busy),
  .done     (done)
);

// File: tb/tb_pll_prog_seq.sv
module tb_pll_prog_seq;

  localparam int HALF = 2;
  localparam int WL   = 300;
  localparam int WS   = 80;
  localparam int LEL  = 2 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, long_wait = 1'b0, pwr_down = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [23:0] wr_data = '0;
  logic spi_sclk, spi_data, spi_le, busy, done;

  always #10 clk = ~clk;

  pll_prog_seq #(.HALF_DIV(HALF), .WAIT_LONG(WL), .WAIT_SHORT(WS)) dut (
    .clk(clk), .rst(rst), .start(start), .long_wait(long_wait),
    .pwr_down(pwr_down), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .spi_sclk(spi_sclk), .spi_data(spi_data), .spi_le(spi_le),
    .busy(busy), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, nw = 0, cap_bits = 0;
  int viol_le = 0, viol_data = 0, done_cnt = 0, done_busy = 0, done_wide = 0, busy_cyc = 0;
  logic [23:0] cap = '0;
  logic [23:0] wv [64];
  int wb [64];
  int rise_t [64];
  int fall_t [64];
  logic p_sclk = 0, p_le = 0, p_data = 0, p_done = 0;
  logic [23:0] cur_r, cur_c, cur_n;
  int gdiff0, gdiff1;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (spi_sclk && !p_sclk) begin
        cap = {cap[22:0], spi_data};
        cap_bits++;
        if (spi_le) viol_le++;
      end
      if (spi_sclk && p_sclk && spi_data != p_data) viol_data++;
      if (spi_le && !p_le && nw < 63) begin
        wv[nw] = cap; wb[nw] = cap_bits; rise_t[nw] = cyc; cap_bits = 0;
      end
      if (!spi_le && p_le && nw < 63) begin
        fall_t[nw] = cyc; nw++;
      end
      if (done) begin
        done_cnt++;
        if (busy) done_busy++;
        if (p_done) done_wide++;
      end
      if (busy) busy_cyc++;
    end
    p_sclk = spi_sclk; p_le = spi_le; p_data = spi_data; p_done = done;
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog: actual=%0d expected<=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_r(input logic [23:0] d);
    return {d[23:22], 1'b0, d[20:2], 2'b01};
  endfunction
  function automatic logic [23:0] exp_c(input logic [23:0] d);
    return {d[23:2], 2'b00};
  endfunction
  function automatic logic [23:0] exp_n(input logic [23:0] d);
    return {d[23:2], 2'b10};
  endfunction

  task automatic write_word(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    int d0 = done_cnt;
    while (done_cnt == d0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(done_cnt > d0, req, "done reached", done_cnt, d0 + 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_words(input int b, input string req);
    chk(nw - b == 3, "R1", "word count", nw - b, 3);
    for (int i = 0; i < 3; i++) begin
      chk(wb[b+i] == 24, "R1", "bits per word", wb[b+i], 24);
      chk(fall_t[b+i] - rise_t[b+i] == LEL, "R4", "latch width", fall_t[b+i] - rise_t[b+i], LEL);
    end
    chk(wv[b]   == exp_r(cur_r), req, "reference word", wv[b],   exp_r(cur_r));
    chk(wv[b+1] == exp_c(cur_c), req, "control word",   wv[b+1], exp_c(cur_c));
    chk(wv[b+2] == exp_n(cur_n), req, "feedback word",  wv[b+2], exp_n(cur_n));
  endtask

  task automatic t_reset();
    idle(3);
    chk(!spi_sclk && !spi_data && !spi_le && !busy && !done, "R10", "outputs in reset",
        {spi_sclk, spi_data, spi_le, busy, done}, 0);
    @(negedge clk) rst = 1'b0;
    chk(!spi_le && !busy && !done, "R10", "outputs after reset", {spi_le, busy, done}, 0);
  endtask

  task automatic t_order();
    int b;
    cur_r = 24'hABCDE7; cur_c = 24'h123457; cur_n = 24'h00FFF3;
    write_word(2'd0, cur_r); write_word(2'd1, cur_c); write_word(2'd2, cur_n);
    b = nw;
    pulse_start();
    wait_done("R1");
    check_words(b, "R2");
    chk(wv[b] == 24'h8BCDE5, "R3", "test bit cleared", wv[b], 24'h8BCDE5);
    chk(viol_le == 0, "R4", "sclk edge during latch", viol_le, 0);
    chk(viol_data == 0, "R1", "data moved with sclk high", viol_data, 0);
  endtask

  task automatic t_handshake();
    int d0 = done_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy, "R6", "busy after accept", busy, 1);
    wait_done("R6");
    chk(!busy, "R6", "busy low at done", busy, 0);
    @(negedge clk);
    chk(!done && !busy, "R6", "done one cycle", {done, busy}, 0);
    chk(done_cnt - d0 == 1, "R6", "done count", done_cnt - d0, 1);
    chk(done_busy == 0 && done_wide == 0, "R6", "done shape", {done_busy, done_wide}, 0);
  endtask

  task automatic t_wait(input logic lw, output int diff);
    int b, g_rc, g_cn;
    @(negedge clk) long_wait = lw;
    b = nw;
    pulse_start();
    wait_done("R5");
    g_rc = rise_t[b+1] - fall_t[b];
    g_cn = rise_t[b+2] - fall_t[b+1];
    diff = g_cn - g_rc;
    chk(diff >= (lw ? WL : WS), "R5", "settle interval", diff, lw ? WL : WS);
    chk(g_rc <= 48 * HALF + 8, "R5", "no wait before control", g_rc, 48 * HALF + 8);
  endtask

  task automatic t_busy_ignore();
    int b = nw;
    int d0 = done_cnt;
    pulse_start();
    idle(30);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    write_word(2'd0, 24'h3C3C3C);
    wait_done("R7");
    idle(400);
    chk(nw - b == 3, "R7", "start while busy dropped", nw - b, 3);
    chk(done_cnt - d0 == 1, "R7", "single run", done_cnt - d0, 1);
    b = nw;
    pulse_start();
    wait_done("R7");
    chk(wv[b] == exp_r(cur_r), "R7", "write while busy dropped", wv[b], exp_r(cur_r));
  endtask

  task automatic t_dirty();
    int b = nw;
    @(negedge clk) pwr_down = 1'b1;
    cur_n = 24'h0ABCD1;
    write_word(2'd2, cur_n);
    idle(40);
    chk(nw == b && !busy, "R8", "no run while down", nw - b, 0);
    @(negedge clk) pwr_down = 1'b0;
    wait_done("R8");
    check_words(b, "R8");
  endtask

  task automatic t_clean();
    int b = nw;
    int bc = busy_cyc;
    @(negedge clk) pwr_down = 1'b1;
    idle(10);
    @(negedge clk) pwr_down = 1'b0;
    idle(300);
    chk(nw == b && busy_cyc == bc, "R9", "flag consumed, no rerun", nw - b, 0);
    @(negedge clk) pwr_down = 1'b1;
    write_word(2'd2, cur_n ^ 24'h000003);
    idle(10);
    @(negedge clk) pwr_down = 1'b0;
    idle(300);
    chk(nw == b && busy_cyc == bc, "R9", "same field, no rerun", busy_cyc - bc, 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_handshake();
    t_wait(1'b0, gdiff0);
    t_wait(1'b1, gdiff1);
    chk(gdiff1 - gdiff0 == WL - WS, "R5", "long minus short", gdiff1 - gdiff0, WL - WS);
    t_busy_ignore();
    t_dirty();
    t_clean();
    summary();
  end

endmodule